// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block drives one external analog-to-digital converter on behalf of several voltage inputs and one temperature sensor. Software loads an 8-bit enable mask, in which the most significant bit stands for channel 0, and pulses a go input. The sequencer then requests conversions on the enabled channels one at a time, always from the lowest channel number upward. It hands out the one-cycle start pulse, waits for the converter's done pulse, and tags each 12-bit result with a 4-bit source address to form a 16-bit word.

A mode input selects between a single sweep, which stops after the highest enabled channel, and continuous operation, which wraps back to the lowest enabled channel. An internal timer raises a temperature request once per programmable period (5 ms at the default clock). The request is served only while no conversion is outstanding, and it takes precedence over the next voltage channel. Each temperature result produces two consecutive words: the raw reading and a running average of the readings.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, conv_start and res_valid are low, and no conversion is requested until go is accepted or the temperature timer expires.
- R2: Channel n is enabled by cmd_mask bit (7 - n), so bit 7 selects channel 0 and bit 0 selects channel 7; conv_chan carries the channel number 0..7.
- R3: A go pulse with an all-zero mask starts no voltage conversion.
- R4: Within a sweep, the enabled channels are converted once each, in strictly ascending channel order.
- R5: conv_start is high for exactly one cycle per conversion, and no new start is issued until the converter has answered the previous one with conv_done.
- R6: The cycle after an accepted conv_done, res_valid is high for one cycle, and res_word[15:12] holds the source address (0..7 voltage, 8 temperature) while res_word[11:0] holds conv_data unchanged.
- R7: With auto_mode low, the sweep ends after the highest enabled channel. With auto_mode high at that point, the sequencer restarts at the lowest enabled channel of the latched mask.
- R8: Every TEMP_PERIOD cycles a temperature conversion (conv_chan = 8) is requested. It starts only while no conversion is outstanding, and it goes ahead of the next voltage channel.
- R9: The cycle after a temperature word, a word with address 9 follows. It carries the averaged reading: the first reading itself, and after that avg + ((reading - avg) >>> AVG_SHIFT) in 12-bit two's complement.
- R10: The mask is latched when go is accepted. A go pulse while a sweep is active is ignored.
- R11: conv_done is ignored while no conversion is outstanding, and it produces no result word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mask | input | 8 | Channel enable mask, bit 7 = channel 0 |
| go | input | 1 | Start a sweep with the current mask |
| auto_mode | input | 1 | 1 = wrap after the last channel, 0 = stop |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Address of the requested conversion |
| conv_done | input | 1 | Converter finished, conv_data valid |
| conv_data | input | 12 | Converter result |
| res_valid | output | 1 | res_word valid this cycle |
| res_word | output | 16 | Address in [15:12], value in [11:0] |

## Verification
The hardest case to reach is a temperature request that falls due in the middle of a voltage sweep, while the converter is still busy. The bench runs many sweeps with random masks, and the converter model answers with random latencies, so timer expiries land at many different points of a sweep. The bench then checks the order of the voltage channels that follow, and the spacing of the temperature starts. Switching auto_mode off during continuous operation is timed so that the change lands while a channel other than the last one is outstanding.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_AVG  = 2'd2
  } seq_state_e;

  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_TEMP = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_TAVG = 4'd9;
endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int PERIOD = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(PERIOD - 1));
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/seq_lowest_pick.sv
module seq_lowest_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/seq_temp_avg.sv
module seq_temp_avg #(
  parameter int W     = 12,
  parameter int SHIFT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] sample,
  output logic [W-1:0] avg
);
  logic [W-1:0]      avg_q, avg_d;
  logic              ok_q, ok_d;
  logic signed [W:0] diff, step, sum;

  always_comb begin
    diff  = $signed({sample[W-1], sample}) - $signed({avg_q[W-1], avg_q});
    step  = diff >>> SHIFT;
    sum   = $signed({avg_q[W-1], avg_q}) + step;
    avg_d = avg_q;
    ok_d  = ok_q;
    if (upd) begin
      avg_d = ok_q ? sum[W-1:0] : sample;
      ok_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= '0;
      ok_q  <= 1'b0;
    end else if (upd) begin
      avg_q <= avg_d;
      ok_q  <= ok_d;
    end
  end

  assign avg = avg_q;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import seq_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int DATA_W      = 12,
  parameter int TEMP_PERIOD = 250000,
  parameter int AVG_SHIFT   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          cmd_mask,
  input  logic                     go,
  input  logic                     auto_mode,
  output logic                     conv_start,
  output logic [ADDR_W-1:0]        conv_chan,
  input  logic                     conv_done,
  input  logic [DATA_W-1:0]        conv_data,
  output logic                     res_valid,
  output logic [ADDR_W+DATA_W-1:0] res_word
);
  localparam int IDX_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int WORD_W = ADDR_W + DATA_W;

  seq_state_e        state_q, state_d;
  logic [N_CH-1:0]   chan_en, mask_q, mask_d, todo_q, todo_d, todo_nx;
  logic              active_q, active_d;
  logic              pend_q, pend_d, take_temp;
  logic              start_q, start_d;
  logic [ADDR_W-1:0] chan_q, chan_d;
  logic              istemp_q, istemp_d;
  logic              rv_q, rv_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              go_take, avg_upd, tick, pick_found;
  logic [IDX_W-1:0]  pick_idx;
  logic [DATA_W-1:0] avg_val;

  // channel n is enabled by the mask bit at the opposite end
  for (genvar g = 0; g < N_CH; g++) begin : g_rev
    assign chan_en[g] = cmd_mask[N_CH-1-g];
    assign todo_nx[g] = todo_q[g] & (chan_q != ADDR_W'(g));
  end

  seq_tick_timer #(.PERIOD(TEMP_PERIOD)) u_timer (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick)
  );

  seq_lowest_pick #(.N(N_CH), .IW(IDX_W)) u_pick (
    .vec   (todo_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  seq_temp_avg #(.W(DATA_W), .SHIFT(AVG_SHIFT)) u_avg (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (avg_upd),
    .sample (conv_data),
    .avg    (avg_val)
  );

  always_comb begin
    state_d   = state_q;
    mask_d    = mask_q;
    todo_d    = todo_q;
    active_d  = active_q;
    start_d   = 1'b0;
    chan_d    = chan_q;
    istemp_d  = istemp_q;
    rv_d      = 1'b0;
    word_d    = word_q;
    take_temp = 1'b0;
    avg_upd   = 1'b0;
    go_take   = go & ~active_q & (|chan_en);

    if (go_take) begin
      active_d = 1'b1;
      mask_d   = chan_en;
      todo_d   = chan_en;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          take_temp = 1'b1;
          start_d   = 1'b1;
          chan_d    = ADDR_TEMP;
          istemp_d  = 1'b1;
          state_d   = ST_WAIT;
        end else if (active_q && pick_found) begin
          start_d  = 1'b1;
          chan_d   = ADDR_W'(pick_idx);
          istemp_d = 1'b0;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (conv_done) begin
          rv_d   = 1'b1;
          word_d = {chan_q, conv_data};
          if (istemp_q) begin
            avg_upd = 1'b1;
            state_d = ST_AVG;
          end else begin
            state_d = ST_IDLE;
            if (todo_nx == '0) begin
              if (auto_mode) todo_d = mask_q;
              else begin
                todo_d   = '0;
                active_d = 1'b0;
              end
            end else begin
              todo_d = todo_nx;
            end
          end
        end
      end
      ST_AVG: begin
        rv_d    = 1'b1;
        word_d  = {ADDR_TAVG, avg_val};
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    pend_d = (pend_q & ~take_temp) | tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      todo_q   <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      start_q  <= 1'b0;
      chan_q   <= '0;
      istemp_q <= 1'b0;
      rv_q     <= 1'b0;
      word_q   <= '0;
    end else begin
      state_q  <= state_d;
      mask_q   <= mask_d;
      todo_q   <= todo_d;
      active_q <= active_d;
      pend_q   <= pend_d;
      start_q  <= start_d;
      chan_q   <= chan_d;
      istemp_q <= istemp_d;
      rv_q     <= rv_d;
      word_q   <= word_d;
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign res_valid  = rv_q;
  assign res_word   = word_q;
endmodule

// File: rtl/seq_chk.sv
module seq_chk
  import seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     conv_start,
  input logic [ADDR_W-1:0]        conv_chan,
  input logic                     conv_done,
  input logic [DATA_W-1:0]        conv_data,
  input logic                     res_valid,
  input logic [ADDR_W+DATA_W-1:0] res_word
);
  logic              outst_q;
  logic [ADDR_W-1:0] hold_q;
  logic              accept;
  logic [ADDR_W-1:0] tag_now;

  assign accept  = conv_done & (outst_q | conv_start);
  assign tag_now = conv_start ? conv_chan : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (conv_start) begin
        outst_q <= 1'b1;
        hold_q  <= conv_chan;
      end else if (conv_done) begin
        outst_q <= 1'b0;
      end
    end
  end

  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r5_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !outst_q);

  a_r6_result_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  a_r6_word_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (res_word == {$past(tag_now), $past(conv_data)}));

  a_r9_avg_follows_temp: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_word[ADDR_W+DATA_W-1:DATA_W] == ADDR_TAVG)
      |-> $past(res_valid && res_word[ADDR_W+DATA_W-1:DATA_W] == ADDR_TEMP));

  a_r11_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_word[ADDR_W+DATA_W-1:DATA_W] != ADDR_TAVG) |-> $past(accept));
endmodule

bind conv_sequencer seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_done  (conv_done),
  .conv_data  (conv_data),
  .res_valid  (res_valid),
  .res_word   (res_word)
);

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  localparam int TPER = 400;
  localparam int ASH  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd_mask = '0;
  logic        go = 1'b0;
  logic        auto_mode = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        res_valid;
  logic [15:0] res_word;

  conv_sequencer #(.N_CH(8), .DATA_W(12), .TEMP_PERIOD(TPER), .AVG_SHIFT(ASH)) uut (
    .clk (clk), .rst_n (rst_n), .cmd_mask (cmd_mask), .go (go), .auto_mode (auto_mode),
    .conv_start (conv_start), .conv_chan (conv_chan), .conv_done (conv_done),
    .conv_data (conv_data), .res_valid (res_valid), .res_word (res_word)
  );

  always #10 clk = ~clk;

  int n_checks = 0, n_errors = 0;
  bit [7:0] b_mask, b_todo;
  bit b_active, busy, cur_last, stray, prev_start, b_avg_ok;
  int dly, b_avg, vstarts, vres, tstarts, avg_words, spurious, last_vchan;
  longint cyc = 0, last_temp = -1;
  logic [3:0] cur_chan;
  logic [15:0] exp_q[$];
  bit last_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit [7:0] rev(input bit [7:0] m);
    bit [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m[7-i];
    return r;
  endfunction

  // converter model and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      conv_done = 1'b0;
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          spurious++;
          chk(1'b0, "R11", "result without conversion", res_word, 0);
        end else begin
          logic [15:0] w;
          bit l;
          w = exp_q.pop_front();
          l = last_q.pop_front();
          chk(res_word == w, "R6", "result word", res_word, w);
          if (res_word[15:12] == 4'd9) avg_words++;
          if (res_word[15:12] < 4'd8) vres++;
          if (l) begin
            if (auto_mode) b_todo = b_mask;
            else b_active = 1'b0;
          end
        end
      end
      if (conv_start) begin
        chk(!prev_start, "R5", "start longer than one cycle", 1, 0);
        chk(!busy, "R5", "start while busy", busy, 0);
        if (conv_chan == 4'd8) begin
          tstarts++;
          if (last_temp >= 0)
            chk((cyc - last_temp >= TPER - 16) && (cyc - last_temp <= TPER + 16),
                "R8", "temperature spacing", cyc - last_temp, TPER);
          last_temp = cyc;
          cur_last = 1'b0;
        end else begin
          int e;
          e = lowest(b_todo);
          chk(b_active && e >= 0, "R3", "voltage start without sweep", conv_chan, e);
          chk(conv_chan == e, "R4", "channel order", conv_chan, e);
          if (e >= 0) b_todo[e] = 1'b0;
          cur_last = (b_todo == 0);
          last_vchan = conv_chan;
          vstarts++;
        end
        busy = 1'b1;
        cur_chan = conv_chan;
        dly = 1 + int'($urandom % 8);
      end else if (busy) begin
        dly--;
        if (dly == 0) begin
          conv_done = 1'b1;
          conv_data = 12'($urandom);
          busy = 1'b0;
          if (cur_chan == 4'd8) begin
            int s;
            exp_q.push_back({4'd8, conv_data}); last_q.push_back(1'b0);
            s = int'($signed(conv_data));
            if (!b_avg_ok) b_avg = s;
            else b_avg = b_avg + ((s - b_avg) >>> ASH);
            b_avg_ok = 1'b1;
            exp_q.push_back({4'd9, 12'(b_avg)}); last_q.push_back(1'b0);
          end else begin
            exp_q.push_back({cur_chan, conv_data}); last_q.push_back(cur_last);
          end
        end
      end else if (stray) begin
        conv_done = 1'b1;
        conv_data = 12'h5A5;
        stray = 1'b0;
      end
      prev_start = conv_start;
    end
  end

  task automatic do_go(input logic [7:0] m);
    @(negedge clk);
    cmd_mask = m;
    go = 1'b1;
    if (!b_active && m != 0) begin
      b_active = 1'b1;
      b_mask = rev(m);
      b_todo = b_mask;
    end
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (b_active || busy || exp_q.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic single(input logic [7:0] m);
    int r0, s0;
    r0 = vres;
    do_go(m);
    wait_idle();
    chk(vres - r0 == $countones(m), "R7", "results in single sweep", vres - r0, $countones(m));
    s0 = vstarts;
    repeat (15) @(negedge clk);
    chk(vstarts == s0, "R7", "starts after sweep end", vstarts - s0, 0);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(conv_start == 0 && res_valid == 0, "R1", "outputs in reset", {conv_start, res_valid}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(vstarts == 0 && tstarts == 0, "R1", "idle after reset", vstarts + tstarts, 0);

    begin : zero_mask
      int s0;
      s0 = vstarts;
      do_go(8'h00);
      repeat (30) @(negedge clk);
      chk(vstarts == s0, "R3", "zero mask starts", vstarts - s0, 0);
    end

    single(8'h80);
    chk(last_vchan == 0, "R2", "mask bit 7 channel", last_vchan, 0);
    single(8'h01);
    chk(last_vchan == 7, "R2", "mask bit 0 channel", last_vchan, 7);
    single(8'hA5);
    single(8'hFF);

    begin : ignore_go
      int r0, s0;
      r0 = vres;
      do_go(8'h0F);
      s0 = vstarts;
      do @(negedge clk); while (vstarts == s0);
      do_go(8'hF0);
      wait_idle();
      chk(vres - r0 == 4, "R10", "go during sweep ignored", vres - r0, 4);
    end

    begin : auto_run
      int r0;
      r0 = vres;
      auto_mode = 1'b1;
      do_go(8'h24);
      do @(negedge clk); while (vres < r0 + 6);
      do @(negedge clk);
      while (!(busy && cur_chan < 8 && !cur_last && dly >= 2 && exp_q.size() == 0));
      auto_mode = 1'b0;
      wait_idle();
      chk(vres - r0 >= 7 && ((vres - r0) % 2) == 0, "R7", "autocycle wraps",
          vres - r0, 8);
    end

    begin : stray_done
      wait_idle();
      stray = 1'b1;
      repeat (10) @(negedge clk);
      chk(spurious == 0, "R11", "stray done results", spurious, 0);
    end

    for (int k = 0; k < 25; k++) single(8'($urandom));

    repeat (1000) @(negedge clk);
    wait_idle();
    chk(tstarts >= 3, "R8", "temperature conversions", tstarts, 3);
    chk(avg_words == tstarts, "R9", "average words", avg_words, tstarts);
    finish_up();
  end
endmodule